// File: doc/BRIEF.md
# DRAM Strobe Decoder with Compressed Test Mode

This block is the control side of a multiplexed-address dynamic memory. It samples the active-low row strobe, column strobe, write enable and output enable on a fast clock. It decides what kind of cycle each row-strobe low period is, and from that it drives row and column access strobes to the cell array. It keeps the internal refresh row counter used by refreshes that carry no address.

The block also supports a parallel test mode that speeds up array test. Test mode is entered when the column strobe and write enable are both low before the row strobe falls. While it is active, one written bit fills a group of 16 cells. A read of that group reports whether all 16 cells hold the same value.

The order of strobe edges is decided by which falling edge the synchroniser sees first. A small behavioural array of the low row and column bits is included so the data path can be checked end to end.

Top module: `dram_tm_ctrl`

## Requirements
- R1: After reset, test_mode_o is 0, ref_row_o is 0 and dq_oe_o is 0.
- R2: A row-strobe fall while the column strobe is already low and write enable is high is a counter refresh. It opens the row given by ref_row_o, and ref_row_o then steps by one, wrapping from 2047 to 0.
- R3: A row-strobe fall while the column strobe is already low and write enable is also low sets test_mode_o and performs a counter refresh exactly as in R2.
- R4: A row-strobe low period in which the column strobe never goes low refreshes the row on addr_i. It leaves ref_row_o unchanged and clears test_mode_o.
- R5: A counter refresh with write enable high clears test_mode_o.
- R6: In test mode, normal read and write cycles and further entry cycles leave test_mode_o at 1. Entry cycles still advance ref_row_o.
- R7: In normal mode, a write stores dq_i at the row and column given by the low address bits, and a later read of that location returns the same value on dq_o.
- R8: A test-mode write ignores column bits 1:0. It writes dq_i[0] into every DQ bit of the four columns that share the remaining column bits, which is 16 cells.
- R9: A test-mode read drives all four dq_o bits to 1 when the 16 cells of the group agree, and to 0 when they differ.
- R10: dq_oe_o is 1 only while a read result is held and oe_ni is low. It drops after a write access and at the row-strobe rise.
- R11: Several column-strobe falls within one row-strobe low period each access a new column of the same row.
- R12: When the row and column strobe falls are seen in the same sample, the cycle is treated as row first. It is an ordinary access, with no refresh counter change and no test-mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DQ_W | Write data |
| row_stb_o | output | 1 | One-clock row open pulse |
| row_addr_o | output | ADDR_W | Row being opened |
| col_stb_o | output | 1 | One-clock column access pulse |
| col_addr_o | output | ADDR_W | Column of the access |
| wr_o | output | 1 | Column access is a write |
| ref_row_o | output | ADDR_W | Internal refresh row counter |
| test_mode_o | output | 1 | Compressed test mode active |
| dq_o | output | DQ_W | Read result |
| dq_oe_o | output | 1 | Read result drive enable |

## Verification
The bench goes after the edge-order corner cases. A column strobe falling in the same sample as the row strobe must give an ordinary access; a decoder that got this wrong would count a refresh or drop the column. A test-mode exit through an address-driven refresh is checked, because a design that missed it would leave group writes corrupting 16 cells. Group compression is checked by writing groups in test mode and reading every cell back in normal mode, and then by breaking one cell so the agreement flag must read 0. Missing column-bit masking or partial fills show up there. The counter is driven through a full wrap, because a wrong width or a missed step during entry cycles would put refreshes on the wrong rows.

// File: rtl/dram_tm_pkg.sv
`timescale 1ns/1ps
package dram_tm_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_ROW  = 2'd1,
    CYC_COL  = 2'd2,
    CYC_REF  = 2'd3
  } cyc_state_e;
endpackage

// File: rtl/tm_strobe_sync.sv
`timescale 1ns/1ps
module tm_strobe_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '1;
        prev_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], sig_i[b]};
        prev_q <= pipe_q[STAGES-1];
      end
    end
    assign lvl_o[b]  = pipe_q[STAGES-1];
    assign prev_o[b] = prev_q;
  end
endmodule

// File: rtl/tm_cycle_decode.sv
`timescale 1ns/1ps
module tm_cycle_decode
  import dram_tm_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_lvl_i,
  input  logic              ras_prev_i,
  input  logic              cas_lvl_i,
  input  logic              cas_prev_i,
  input  logic              we_lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              row_stb_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              col_stb_o,
  output logic [ADDR_W-1:0] col_addr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] ref_row_o,
  output logic              test_mode_o
);
  cyc_state_e        st_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_prev_i & ~ras_lvl_i;
  assign ras_rise = ~ras_prev_i & ras_lvl_i;
  assign cas_fall = cas_prev_i & ~cas_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= CYC_IDLE;
      cnt_q       <= '0;
      row_stb_o   <= 1'b0;
      row_addr_o  <= '0;
      col_stb_o   <= 1'b0;
      col_addr_o  <= '0;
      wr_o        <= 1'b0;
      test_mode_o <= 1'b0;
    end else begin
      row_stb_o <= 1'b0;
      col_stb_o <= 1'b0;
      unique case (st_q)
        CYC_IDLE: begin
          if (ras_fall) begin
            row_stb_o <= 1'b1;
            if (!cas_prev_i) begin
              // column strobe seen low before the row strobe: counter refresh
              st_q        <= CYC_REF;
              row_addr_o  <= cnt_q;
              cnt_q       <= cnt_q + 1'b1;
              test_mode_o <= ~we_lvl_i;
            end else begin
              st_q       <= CYC_ROW;
              row_addr_o <= addr_i;
            end
          end
        end
        CYC_ROW: begin
          if (ras_rise) begin
            st_q        <= CYC_IDLE;
            test_mode_o <= 1'b0;
          end else if (!cas_lvl_i) begin
            st_q       <= CYC_COL;
            col_stb_o  <= 1'b1;
            col_addr_o <= addr_i;
            wr_o       <= ~we_lvl_i;
          end
        end
        CYC_COL: begin
          if (ras_rise) begin
            st_q <= CYC_IDLE;
          end else if (cas_fall) begin
            col_stb_o  <= 1'b1;
            col_addr_o <= addr_i;
            wr_o       <= ~we_lvl_i;
          end
        end
        CYC_REF: begin
          if (ras_rise) st_q <= CYC_IDLE;
        end
        default: st_q <= CYC_IDLE;
      endcase
    end
  end

  assign ref_row_o = cnt_q;
endmodule

// File: rtl/tm_cell_array.sv
`timescale 1ns/1ps
module tm_cell_array #(
  parameter int ADDR_W = 11,
  parameter int DQ_W   = 4,
  parameter int AR_W   = 2,
  parameter int AC_W   = 4,
  parameter int GRP_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic              tm_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  input  logic [DQ_W-1:0]   wdata_i,
  output logic [DQ_W-1:0]   rdata_o
);
  localparam int IDX_W  = AR_W + AC_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int GRP_N  = 1 << GRP_W;
  localparam int CELL_N = GRP_N * DQ_W;

  logic [DQ_W-1:0]   mem_q [DEPTH];
  logic [IDX_W-1:0]  idx, base;
  logic [CELL_N-1:0] grp_bits;
  logic              grp_agree;

  assign idx  = {row_i[AR_W-1:0], col_i[AC_W-1:0]};
  assign base = {row_i[AR_W-1:0], col_i[AC_W-1:GRP_W], {GRP_W{1'b0}}};

  always_comb begin
    for (int g = 0; g < GRP_N; g++) begin
      grp_bits[g*DQ_W +: DQ_W] = mem_q[base + IDX_W'(g)];
    end
  end
  assign grp_agree = (&grp_bits) | ~(|grp_bits);

  always_ff @(posedge clk_i) begin
    if (acc_i && wr_i) begin
      if (tm_i) begin
        for (int g = 0; g < GRP_N; g++) begin
          mem_q[base + IDX_W'(g)] <= {DQ_W{wdata_i[0]}};
        end
      end else begin
        mem_q[idx] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (acc_i && !wr_i) begin
      rdata_o <= tm_i ? {DQ_W{grp_agree}} : mem_q[idx];
    end
  end
endmodule

// File: rtl/dram_tm_ctrl.sv
`timescale 1ns/1ps
module dram_tm_ctrl #(
  parameter int ADDR_W = 11,
  parameter int DQ_W   = 4,
  parameter int AR_W   = 2,
  parameter int AC_W   = 4,
  parameter int GRP_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              row_stb_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              col_stb_o,
  output logic [ADDR_W-1:0] col_addr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] ref_row_o,
  output logic              test_mode_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o
);
  localparam int N_STB = 4;
  localparam int I_RAS = 0, I_CAS = 1, I_WE = 2, I_OE = 3;

  logic [N_STB-1:0] stb_lvl, stb_prev;
  logic             ras_rise, rd_valid_q;

  tm_strobe_sync #(.N(N_STB), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({oe_ni, we_ni, cas_ni, ras_ni}),
    .lvl_o  (stb_lvl),
    .prev_o (stb_prev)
  );

  tm_cycle_decode #(.ADDR_W(ADDR_W)) i_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ras_lvl_i   (stb_lvl[I_RAS]),
    .ras_prev_i  (stb_prev[I_RAS]),
    .cas_lvl_i   (stb_lvl[I_CAS]),
    .cas_prev_i  (stb_prev[I_CAS]),
    .we_lvl_i    (stb_lvl[I_WE]),
    .addr_i      (addr_i),
    .row_stb_o   (row_stb_o),
    .row_addr_o  (row_addr_o),
    .col_stb_o   (col_stb_o),
    .col_addr_o  (col_addr_o),
    .wr_o        (wr_o),
    .ref_row_o   (ref_row_o),
    .test_mode_o (test_mode_o)
  );

  tm_cell_array #(
    .ADDR_W(ADDR_W), .DQ_W(DQ_W), .AR_W(AR_W), .AC_W(AC_W), .GRP_W(GRP_W)
  ) i_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (col_stb_o),
    .wr_i    (wr_o),
    .tm_i    (test_mode_o),
    .row_i   (row_addr_o),
    .col_i   (col_addr_o),
    .wdata_i (dq_i),
    .rdata_o (dq_o)
  );

  assign ras_rise = ~stb_prev[I_RAS] & stb_lvl[I_RAS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_valid_q <= 1'b0;
    else if (ras_rise)  rd_valid_q <= 1'b0;
    else if (col_stb_o) rd_valid_q <= ~wr_o;
  end

  assign dq_oe_o = rd_valid_q & ~stb_lvl[I_OE];
endmodule

// File: rtl/tm_ctrl_checker.sv
`timescale 1ns/1ps
module tm_ctrl_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              row_stb_o,
  input logic [ADDR_W-1:0] row_addr_o,
  input logic              col_stb_o,
  input logic              wr_o,
  input logic [ADDR_W-1:0] ref_row_o,
  input logic              test_mode_o,
  input logic              dq_oe_o
);
  AST_REF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_row_o) |-> ref_row_o == ADDR_W'($past(ref_row_o) + 1'b1)); // R2

  AST_REF_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_stb_o && !$stable(ref_row_o)) |-> row_addr_o == $past(ref_row_o)); // R2

  AST_TM_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_mode_o) |-> (row_stb_o && !$stable(ref_row_o))); // R3

  AST_CNT_ONLY_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_row_o) |-> row_stb_o); // R4

  AST_WR_DROP_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_o && wr_o) |=> !dq_oe_o); // R10
endmodule

bind dram_tm_ctrl tm_ctrl_checker #(.ADDR_W(ADDR_W)) i_tm_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .row_stb_o   (row_stb_o),
  .row_addr_o  (row_addr_o),
  .col_stb_o   (col_stb_o),
  .wr_o        (wr_o),
  .ref_row_o   (ref_row_o),
  .test_mode_o (test_mode_o),
  .dq_oe_o     (dq_oe_o)
);

// File: tb/test_dram_tm_ctrl.sv
`timescale 1ns/1ps
module test_dram_tm_ctrl;
  localparam int AW = 11;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic row_stb, col_stb, wr, tm, dq_oe;
  logic [AW-1:0] row_addr, col_addr, ref_row;
  logic [DW-1:0] dq_out;

  int total = 0, bad = 0;
  logic [3:0] mdl [64];
  int exp_cnt = 0;
  bit exp_tm = 1'b0;

  always #2 clk = ~clk;

  dram_tm_ctrl i_dram_tm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras), .cas_ni(cas), .we_ni(we),
    .oe_ni(oe), .addr_i(addr), .dq_i(dq_in), .row_stb_o(row_stb),
    .row_addr_o(row_addr), .col_stb_o(col_stb), .col_addr_o(col_addr),
    .wr_o(wr), .ref_row_o(ref_row), .test_mode_o(tm), .dq_o(dq_out),
    .dq_oe_o(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int ix(input int r, input int c);
    return (r % 4) * 16 + (c % 16);
  endfunction

  function automatic logic [3:0] exp_rd(input int r, input int c);
    int ones = 0;
    if (!exp_tm) return mdl[ix(r, c)];
    for (int g = 0; g < 4; g++) ones += $countones(mdl[ix(r, (c & ~3) + g)]);
    return (ones == 0 || ones == 16) ? 4'hF : 4'h0;
  endfunction

  task automatic cbr(input bit we_low);
    cas = 1'b0; we = ~we_low; cyc(4);
    ras = 1'b0; cyc(6);
    ras = 1'b1; cas = 1'b1; we = 1'b1; cyc(6);
    exp_cnt = (exp_cnt + 1) % 2048;
    exp_tm = we_low;
  endtask

  task automatic ras_only(input int r);
    addr = AW'(r); ras = 1'b0; cyc(6);
    ras = 1'b1; cyc(6);
    exp_tm = 1'b0;
  endtask

  task automatic wr_cell(input int r, input int c, input logic [3:0] d);
    addr = AW'(r); ras = 1'b0; cyc(6);
    addr = AW'(c); we = 1'b0; dq_in = d; cas = 1'b0; cyc(6);
    cas = 1'b1; we = 1'b1; cyc(4);
    ras = 1'b1; cyc(6);
    if (exp_tm) for (int g = 0; g < 4; g++) mdl[ix(r, (c & ~3) + g)] = {4{d[0]}};
    else mdl[ix(r, c)] = d;
  endtask

  task automatic rd_cell(input int r, input int c, input bit oe_low,
                         output logic [3:0] d, output bit seen);
    addr = AW'(r); ras = 1'b0; cyc(6);
    addr = AW'(c); oe = ~oe_low; cas = 1'b0; cyc(8);
    @(negedge clk); d = dq_out; seen = dq_oe;
    cas = 1'b1; oe = 1'b1; cyc(4);
    ras = 1'b1; cyc(6);
  endtask

  initial begin : watchdog
    cyc(150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [3:0] d;
    bit seen;
    cyc(3); @(negedge clk);
    chk(tm == 1'b0, "R1 test_mode", tm, 0);
    chk(ref_row == '0, "R1 ref_row", ref_row, 0);
    chk(dq_oe == 1'b0, "R1 dq_oe", dq_oe, 0);
    rst_n = 1'b1; cyc(4);

    // R7 normal sweep over the whole behavioural array
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++) wr_cell(r, c, 4'((r * 5 + c * 3 + 1) & 15));
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++) begin
        rd_cell(r, c, 1'b1, d, seen);
        chk(d == exp_rd(r, c), "R7 read data", d, exp_rd(r, c));
        chk(seen, "R10 oe during read", seen, 1);
      end
    @(negedge clk);
    chk(dq_oe == 1'b0, "R10 oe after ras rise", dq_oe, 0);
    rd_cell(2, 7, 1'b0, d, seen);
    chk(!seen, "R10 oe_ni high", seen, 0);

    // R11 page mode: three columns in one row-strobe period
    addr = AW'(1); ras = 1'b0; cyc(6);
    oe = 1'b0;
    for (int k = 0; k < 3; k++) begin
      addr = AW'(k * 5); cas = 1'b0; cyc(8);
      @(negedge clk);
      chk(dq_out == mdl[ix(1, k * 5)], "R11 page read", dq_out, mdl[ix(1, k * 5)]);
      cas = 1'b1; cyc(5);
    end
    oe = 1'b1; ras = 1'b1; cyc(6);

    // R2 counter refresh
    for (int k = 0; k < 3; k++) begin
      cbr(1'b0);
      @(negedge clk);
      chk(ref_row == AW'(exp_cnt), "R2 counter step", ref_row, exp_cnt);
    end
    chk(tm == 1'b0, "R2 no test mode", tm, 0);

    // R3 entry
    cbr(1'b1);
    @(negedge clk);
    chk(tm == 1'b1, "R3 entry sets mode", tm, 1);
    chk(ref_row == AW'(exp_cnt), "R3 entry refreshes", ref_row, exp_cnt);

    // R8 group writes with varying ignored low column bits
    for (int r = 0; r < 4; r++)
      for (int h = 0; h < 4; h++) wr_cell(r, h * 4 + r, 4'((r + h) & 1) | 4'hE);
    @(negedge clk);
    chk(tm == 1'b1, "R6 access keeps mode", tm, 1);
    for (int r = 0; r < 4; r++)
      for (int h = 0; h < 4; h++) begin
        rd_cell(r, h * 4 + 3 - r, 1'b1, d, seen);
        chk(d == 4'hF, "R9 group agrees", d, 15);
      end
    cbr(1'b1);
    @(negedge clk);
    chk(tm == 1'b1, "R6 re-entry keeps mode", tm, 1);
    chk(ref_row == AW'(exp_cnt), "R6 re-entry counts", ref_row, exp_cnt);

    // R5 exit and normal readback of every cell of every group
    cbr(1'b0);
    @(negedge clk);
    chk(tm == 1'b0, "R5 exit", tm, 0);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++) begin
        rd_cell(r, c, 1'b1, d, seen);
        chk(d == {4{1'((r + c / 4) & 1)}}, "R8 cell fill", d, {4{1'((r + c / 4) & 1)}});
      end

    // R9 broken group reads 0
    wr_cell(2, 9, 4'b0100);
    cbr(1'b1);
    rd_cell(2, 8, 1'b1, d, seen);
    chk(d == 4'h0, "R9 group differs", d, 0);
    rd_cell(2, 1, 1'b1, d, seen);
    chk(d == exp_rd(2, 1), "R9 other group", d, exp_rd(2, 1));

    // R4 address-driven refresh leaves test mode, counter held
    ras_only(3);
    @(negedge clk);
    chk(tm == 1'b0, "R4 exit", tm, 0);
    chk(ref_row == AW'(exp_cnt), "R4 counter held", ref_row, exp_cnt);
    ras_only(1000);
    @(negedge clk);
    chk(ref_row == AW'(exp_cnt), "R4 counter held normal", ref_row, exp_cnt);

    // R12 simultaneous fall is an ordinary access
    wr_cell(1, 5, 4'hA);
    addr = AW'(5); oe = 1'b0; ras = 1'b0; cas = 1'b0; cyc(10);
    @(negedge clk);
    chk(dq_oe && dq_out == 4'hA, "R12 row first read", dq_out, 10);
    chk(ref_row == AW'(exp_cnt), "R12 no refresh", ref_row, exp_cnt);
    chk(tm == 1'b0, "R12 no entry", tm, 0);
    cas = 1'b1; oe = 1'b1; cyc(4); ras = 1'b1; cyc(6);

    // R2 wrap over 2048 rows
    for (int k = 0; k < 2048; k++) begin
      cbr(1'b0);
      if (exp_cnt == 0) begin
        @(negedge clk);
        chk(ref_row == '0, "R2 wrap", ref_row, 0);
      end
    end
    @(negedge clk);
    chk(ref_row == AW'(exp_cnt), "R2 full cycle", ref_row, exp_cnt);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule